// File: doc/BRIEF.md
# Serial Receiver Buffered Data Path

This block sits between the receive shift stage of an asynchronous serial receiver and the host. Each time the shift stage finishes a frame, it hands over up to nine data bits and a framing-error flag. The block stores each frame in a two-entry circular FIFO. Every entry keeps its own ninth bit, framing-error flag and overrun flag next to its data, so the status that belongs to a frame stays with that frame until the frame is read.

When both FIFO entries are occupied, a newly completed frame is not dropped. It stays parked in the shift stage, which then acts as a third buffer level. The parked frame moves into the FIFO one clock after a read frees an entry. A frame is lost only when the shift stage detects a new start bit while the FIFO is still full and the parked frame has not been moved. In that case the next frame written into the FIFO carries the overrun flag.

The host sees the head entry on two ports. The status port shows the ninth bit and both error flags, and the data port shows the low data bits. A read strobe on the data port pops the head entry, so the host reads the status first and then reads the data exactly once per frame.

Top module: `rx_frame_buffer`

## Requirements
- R1: Frames leave the FIFO in the order they arrived, and `rxComplete` is high exactly when the FIFO holds at least one entry.
- R2: A cycle with `dataRd` high while the FIFO holds an entry removes exactly one entry. `dataRd` while the FIFO is empty has no effect.
- R3: The status port shows the head entry. `statNinth` is data bit 8, `rdData` is data bits 7:0, and `statFerr` and `statOvr` are the flags stored with that entry. All four outputs read zero while the FIFO is empty.
- R4: A frame completed (`frameDone`) while both entries are occupied is held in a parked register, and `parkBusy` goes high on the next clock.
- R5: While `parkBusy` is high and the FIFO has a free entry, the parked frame is written into the FIFO at the next clock edge and `parkBusy` falls. A pop frees an entry at its own edge, so the parked frame moves at the edge after the pop.
- R6: `startSeen` while a frame is parked and the FIFO is full discards the parked frame and clears `parkBusy`. `startSeen` with no parked frame has no effect on the stored frames or their flags.
- R7: After a parked frame is discarded, the next frame written into the FIFO has its overrun flag set. Frames written after that one have the flag clear.
- R8: Reset empties the FIFO, clears `parkBusy` and clears any pending overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameDone | input | 1 | One-cycle pulse: shift stage has a completed frame |
| frameData | input | DATA_W | Completed frame data bits |
| frameFerr | input | 1 | Framing error of the completed frame |
| startSeen | input | 1 | One-cycle pulse: shift stage detected a new start bit |
| dataRd | input | 1 | Data port read strobe; pops the head entry |
| rxComplete | output | 1 | FIFO holds at least one frame |
| statNinth | output | 1 | Ninth data bit of the head entry |
| statFerr | output | 1 | Framing-error flag of the head entry |
| statOvr | output | 1 | Overrun flag of the head entry |
| rdData | output | DATA_W-1 | Low data bits of the head entry |
| parkBusy | output | 1 | A completed frame is parked in the shift stage |

## Verification
The properties assume a well-behaved shift stage. It never raises `frameDone` while a frame is parked, and it never raises `frameDone` in the same cycle as `startSeen`. This holds because a new frame can only finish after its start bit, and that start bit has either moved or discarded the parked frame. One checker property monitors this input rule. The stimulus follows it: every `frameDone` pulse is issued only after `parkBusy` has been observed low, and start pulses are always driven in cycles of their own.

// File: rtl/rx_frame_buffer_pkg.sv
package rx_frame_buffer_pkg;

  // Strobes from the control unit to the datapath for one cycle.
  typedef struct packed {
    logic wrEn;       // write one entry into the FIFO
    logic wrFromPark; // write source: 1 = parked frame, 0 = incoming frame
    logic wrOvr;      // overrun flag stored with the written entry
    logic parkLoad;   // capture the incoming frame into the parked register
    logic outEn;      // head entry is valid and may be shown at the ports
  } rxStrobe_t;

  // Flags kept per stored frame.
  typedef struct packed {
    logic ferr;
    logic ovr;
  } rxFlags_t;

endpackage

// File: rtl/rx_frame_buffer_ctrl.sv
module rx_frame_buffer_ctrl
  import rx_frame_buffer_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameDone,
  input  logic             startSeen,
  input  logic             dataRd,
  output rxStrobe_t        strobe,
  output logic [PTR_W-1:0] wrIdx,
  output logic [PTR_W-1:0] rdIdx,
  output logic [CNT_W-1:0] fillLevel,
  output logic             parkValid
);

  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] count;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             parked, ovrPend;

  logic isFull, isEmpty;
  logic moveNow, directWr, parkNow, popNow, dropNow, anyWr;

  always_comb begin
    isFull   = (count == FULL_LVL);
    isEmpty  = (count == '0);
    moveNow  = parked && !isFull;
    directWr = frameDone && !parked && !isFull;
    parkNow  = frameDone && isFull;
    popNow   = dataRd && !isEmpty;
    dropNow  = startSeen && parked && isFull;
    anyWr    = moveNow || directWr;
  end

  always_comb begin
    strobe.wrEn       = anyWr;
    strobe.wrFromPark = moveNow;
    strobe.wrOvr      = ovrPend;
    strobe.parkLoad   = parkNow;
    strobe.outEn      = !isEmpty;
  end

  function automatic logic [PTR_W-1:0] nextIdx(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
      parked  <= 1'b0;
      ovrPend <= 1'b0;
    end else begin
      count <= count + CNT_W'(anyWr) - CNT_W'(popNow);
      if (anyWr)  wrPtr <= nextIdx(wrPtr);
      if (popNow) rdPtr <= nextIdx(rdPtr);
      if (parkNow)                 parked <= 1'b1;
      else if (moveNow || dropNow) parked <= 1'b0;
      if (dropNow)    ovrPend <= 1'b1;
      else if (anyWr) ovrPend <= 1'b0;
    end
  end

  assign wrIdx     = wrPtr;
  assign rdIdx     = rdPtr;
  assign fillLevel = count;
  assign parkValid = parked;

endmodule

// File: rtl/rx_frame_buffer_dp.sv
module rx_frame_buffer_dp
  import rx_frame_buffer_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LOW_W = DATA_W - 1
) (
  input  logic              clk,
  input  rxStrobe_t         strobe,
  input  logic [PTR_W-1:0]  wrIdx,
  input  logic [PTR_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] frameData,
  input  logic              frameFerr,
  output logic              statNinth,
  output logic              statFerr,
  output logic              statOvr,
  output logic [LOW_W-1:0]  rdData
);

  logic [DATA_W-1:0] parkData;
  logic              parkFerr;
  logic [DATA_W-1:0] memData  [DEPTH];
  rxFlags_t          memFlags [DEPTH];

  logic [DATA_W-1:0] wrData;
  rxFlags_t          wrFlags;

  // Parked frame register (the third buffer level).
  always_ff @(posedge clk) begin
    if (strobe.parkLoad) begin
      parkData <= frameData;
      parkFerr <= frameFerr;
    end
  end

  always_comb begin
    wrData       = strobe.wrFromPark ? parkData : frameData;
    wrFlags.ferr = strobe.wrFromPark ? parkFerr : frameFerr;
    wrFlags.ovr  = strobe.wrOvr;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (strobe.wrEn && (wrIdx == PTR_W'(i))) begin
        memData[i]  <= wrData;
        memFlags[i] <= wrFlags;
      end
    end
  end

  always_comb begin
    if (strobe.outEn) begin
      rdData    = memData[rdIdx][LOW_W-1:0];
      statNinth = memData[rdIdx][DATA_W-1];
      statFerr  = memFlags[rdIdx].ferr;
      statOvr   = memFlags[rdIdx].ovr;
    end else begin
      rdData    = '0;
      statNinth = 1'b0;
      statFerr  = 1'b0;
      statOvr   = 1'b0;
    end
  end

endmodule

// File: rtl/rx_frame_buffer.sv
module rx_frame_buffer
  import rx_frame_buffer_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameDone,
  input  logic [DATA_W-1:0] frameData,
  input  logic              frameFerr,
  input  logic              startSeen,
  input  logic              dataRd,
  output logic              rxComplete,
  output logic              statNinth,
  output logic              statFerr,
  output logic              statOvr,
  output logic [DATA_W-2:0] rdData,
  output logic              parkBusy
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rxStrobe_t        strobe;
  logic [PTR_W-1:0] wrIdx, rdIdx;
  logic [CNT_W-1:0] fillLevel;
  logic             parkValid;

  rx_frame_buffer_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameDone (frameDone),
    .startSeen (startSeen),
    .dataRd    (dataRd),
    .strobe    (strobe),
    .wrIdx     (wrIdx),
    .rdIdx     (rdIdx),
    .fillLevel (fillLevel),
    .parkValid (parkValid)
  );

  rx_frame_buffer_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .strobe    (strobe),
    .wrIdx     (wrIdx),
    .rdIdx     (rdIdx),
    .frameData (frameData),
    .frameFerr (frameFerr),
    .statNinth (statNinth),
    .statFerr  (statFerr),
    .statOvr   (statOvr),
    .rdData    (rdData)
  );

  assign rxComplete = (fillLevel != '0);
  assign parkBusy   = parkValid;

endmodule

// File: rtl/rx_frame_buffer_chk.sv
module rx_frame_buffer_chk #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameDone,
  input logic              startSeen,
  input logic              dataRd,
  input logic              rxComplete,
  input logic              statNinth,
  input logic              statFerr,
  input logic              statOvr,
  input logic [DATA_W-2:0] rdData,
  input logic              parkBusy,
  input logic [CNT_W-1:0]  fillLevel
);

  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  // R1: the fill level never exceeds the FIFO depth.
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= FULL_LVL);

  // R1: a frame accepted directly makes the FIFO non-empty.
  a_r1_push_sets_ready: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && !parkBusy && (fillLevel != FULL_LVL) |=> rxComplete);

  // R2: a read of an empty FIFO leaves it empty when nothing is written.
  a_r2_empty_read_ignored: assert property (@(posedge clk) disable iff (!rstN)
    dataRd && !rxComplete && !frameDone && !parkBusy |=> !rxComplete);

  // R3: the status and data ports read zero while the FIFO is empty.
  a_r3_empty_outputs_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rxComplete |-> (rdData == '0) && !statNinth && !statFerr && !statOvr);

  // R4: a frame completed while the FIFO is full is parked.
  a_r4_full_parks: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && (fillLevel == FULL_LVL) |=> parkBusy);

  // R4: input rule, no frame completes while one is parked or alongside a start bit.
  a_r4_frame_rule: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !parkBusy && !startSeen);

  // R5: a parked frame moves as soon as an entry is free.
  a_r5_park_moves: assert property (@(posedge clk) disable iff (!rstN)
    parkBusy && (fillLevel != FULL_LVL) |=> !parkBusy);

  // R6: a start bit while parked and full discards the parked frame.
  a_r6_start_drops: assert property (@(posedge clk) disable iff (!rstN)
    startSeen && parkBusy && (fillLevel == FULL_LVL) |=> !parkBusy);

  // R8: one cycle after reset the FIFO is empty and nothing is parked.
  a_r8_reset_clears: assert property (@(posedge clk)
    !rstN |=> !rxComplete && !parkBusy);

endmodule

bind rx_frame_buffer rx_frame_buffer_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/rx_frame_buffer_tb.sv
module rx_frame_buffer_tb;

  localparam int DATA_W = 9;
  localparam int NVEC   = 17;

  // Opcodes used in the vector table.
  localparam logic [1:0] OP_PUSH  = 2'd0;
  localparam logic [1:0] OP_POP   = 2'd1;
  localparam logic [1:0] OP_START = 2'd2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameDone = 1'b0;
  logic [DATA_W-1:0] frameData = '0;
  logic frameFerr = 1'b0;
  logic startSeen = 1'b0;
  logic dataRd = 1'b0;
  logic rxComplete, statNinth, statFerr, statOvr, parkBusy;
  logic [DATA_W-2:0] rdData;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rx_frame_buffer #(.DATA_W(DATA_W), .DEPTH(2)) u_dut (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .frameData(frameData),
    .frameFerr(frameFerr), .startSeen(startSeen), .dataRd(dataRd),
    .rxComplete(rxComplete), .statNinth(statNinth), .statFerr(statFerr),
    .statOvr(statOvr), .rdData(rdData), .parkBusy(parkBusy)
  );

  // Vector fields: op[14:13] data[12:4] ferr[3] ovr[2] expReady[1] expPark[0].
  // For a push, data/ferr drive the frame. For a pop, data/ferr/ovr are the
  // expected head entry. expReady and expPark are checked after the op.
  localparam logic [14:0] VEC [NVEC] = '{
    {OP_PUSH,  9'h0A5, 1'b0, 1'b0, 1'b1, 1'b0},  // A
    {OP_PUSH,  9'h1C3, 1'b1, 1'b0, 1'b1, 1'b0},  // B, framing error
    {OP_PUSH,  9'h055, 1'b0, 1'b0, 1'b1, 1'b1},  // C parks (R4)
    {OP_POP,   9'h0A5, 1'b0, 1'b0, 1'b1, 1'b1},  // A out, C still parked
    {OP_POP,   9'h1C3, 1'b1, 1'b0, 1'b1, 1'b0},  // B out, C moved (R5)
    {OP_POP,   9'h055, 1'b0, 1'b0, 1'b0, 1'b0},  // C out
    {OP_PUSH,  9'h1FF, 1'b0, 1'b0, 1'b1, 1'b0},  // D, ninth bit set
    {OP_PUSH,  9'h000, 1'b1, 1'b0, 1'b1, 1'b0},  // E
    {OP_PUSH,  9'h0F0, 1'b0, 1'b0, 1'b1, 1'b1},  // F parks
    {OP_START, 9'h000, 1'b0, 1'b0, 1'b1, 1'b0},  // F lost (R6)
    {OP_PUSH,  9'h13C, 1'b0, 1'b0, 1'b1, 1'b1},  // G parks
    {OP_POP,   9'h1FF, 1'b0, 1'b0, 1'b1, 1'b1},  // D out
    {OP_POP,   9'h000, 1'b1, 1'b0, 1'b1, 1'b0},  // E out, G moved with overrun
    {OP_POP,   9'h13C, 1'b0, 1'b1, 1'b0, 1'b0},  // G carries overrun (R7)
    {OP_PUSH,  9'h001, 1'b0, 1'b0, 1'b1, 1'b0},  // H
    {OP_START, 9'h000, 1'b0, 1'b0, 1'b1, 1'b0},  // start, nothing parked
    {OP_POP,   9'h001, 1'b0, 1'b0, 1'b0, 1'b0}   // H clean (R6, R7)
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic push(input logic [DATA_W-1:0] d, input logic f);
    frameDone = 1'b1; frameData = d; frameFerr = f;
    @(negedge clk);
    frameDone = 1'b0; frameData = '0; frameFerr = 1'b0;
  endtask

  task automatic startBit();
    startSeen = 1'b1;
    @(negedge clk);
    startSeen = 1'b0;
  endtask

  // Check the head at the port, then pop it.
  task automatic popCheck(input string tag, input logic [DATA_W-1:0] d,
                          input logic f, input logic o);
    check({tag, " data"},  {23'd0, statNinth, rdData}, {23'd0, d});
    check({tag, " ferr"},  {31'd0, statFerr}, {31'd0, f});
    check({tag, " ovr"},   {31'd0, statOvr},  {31'd0, o});
    dataRd = 1'b1;
    @(negedge clk);
    dataRd = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R8: reset state.
    check("R8 reset ready", {31'd0, rxComplete}, 32'd0);
    check("R8 reset park",  {31'd0, parkBusy},   32'd0);
    check("R3 empty data",  {23'd0, statNinth, rdData}, 32'd0);
    check("R3 empty flags", {30'd0, statFerr, statOvr}, 32'd0);

    // Vector table: R1..R7 ordering, parking, moving, dropping, overrun.
    for (int i = 0; i < NVEC; i++) begin
      logic [14:0] v;
      v = VEC[i];
      case (v[14:13])
        OP_PUSH:  push(v[12:4], v[3]);
        OP_POP:   popCheck($sformatf("R1 R3 vec%0d", i), v[12:4], v[3], v[2]);
        default:  startBit();
      endcase
      check($sformatf("R1 vec%0d ready", i), {31'd0, rxComplete}, {31'd0, v[1]});
      check($sformatf("R4 R5 R6 vec%0d park", i), {31'd0, parkBusy}, {31'd0, v[0]});
    end

    // R2: a read on an empty FIFO is ignored.
    dataRd = 1'b1;
    @(negedge clk);
    dataRd = 1'b0;
    check("R2 empty read ready", {31'd0, rxComplete}, 32'd0);
    push(9'h0AA, 1'b1);
    check("R2 push after empty read", {31'd0, rxComplete}, 32'd1);
    popCheck("R2 head after empty read", 9'h0AA, 1'b1, 1'b0);
    check("R2 empty again", {31'd0, rxComplete}, 32'd0);

    // R8: reset with full FIFO, parked frame and pending overrun.
    push(9'h011, 1'b0);
    push(9'h022, 1'b0);
    push(9'h033, 1'b0);
    startBit();
    push(9'h044, 1'b0);
    check("R8 pre-reset park", {31'd0, parkBusy}, 32'd1);
    doReset();
    check("R8 ready cleared", {31'd0, rxComplete}, 32'd0);
    check("R8 park cleared",  {31'd0, parkBusy},   32'd0);
    push(9'h066, 1'b0);
    popCheck("R8 R7 no stale overrun", 9'h066, 1'b0, 1'b0);

    // R7: overrun flag lands only on the first frame after the loss.
    push(9'h101, 1'b0);
    push(9'h102, 1'b0);
    push(9'h103, 1'b0);
    startBit();
    popCheck("R7 first old", 9'h101, 1'b0, 1'b0);
    popCheck("R7 second old", 9'h102, 1'b0, 1'b0);
    push(9'h104, 1'b1);
    push(9'h105, 1'b0);
    popCheck("R7 flagged frame", 9'h104, 1'b1, 1'b1);
    popCheck("R7 following frame", 9'h105, 1'b0, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule